// File: doc/BRIEF.md
# Trigger-Swapped Ping-Pong Sample Buffer

This block records a continuous stream of parallel converter samples into one of two equally sized memory banks while a host empties the other bank one word at a time. A trigger pulse exchanges the roles of the two banks in a single cycle. No data is copied. Only the bank-select state changes, and that state steers the write and read multiplexers together.

The write bank is a circular window. Its address wraps modulo the bank depth, so once more samples than the depth have arrived, the oldest are overwritten. At an accepted trigger the write pointer and fill level are captured. The host then reads the frozen bank from its oldest sample to its newest. If fewer samples than the depth were taken, the host reads only that many. A trigger that arrives before the host has emptied the frozen bank is dropped, and a sticky overrun flag records the loss.

Detection of the trigger condition, the converter interface and any clock-domain crossing stay outside the block. Everything runs on one clock.

Top module: `pp_capture_buf`

## Requirements
- R1: After reset, wr_bank_o=0, rd_valid_o=0, rd_left_o=0, rd_done_o=1 and overrun_o=0.
- R2: Each cycle with smp_valid_i=1 stores smp_data_i into the current write bank at the next address. The address wraps modulo DEPTH.
- R3: A trigger taken while rd_done_o=1 toggles wr_bank_o on the following cycle.
- R4: On the cycle after an accepted trigger, rd_left_o equals min(samples written since the previous accepted trigger or reset, DEPTH).
- R5: The frozen bank reads out in chronological order, oldest first. The readout is the last rd_left_o samples written before the trigger.
- R6: A read request while rd_left_o>0 yields rd_valid_o=1 with the sample on rd_data_o exactly one cycle later, and rd_left_o drops by one.
- R7: A read request while rd_left_o=0 is ignored. rd_valid_o stays 0 on the next cycle and rd_left_o stays 0.
- R8: rd_done_o is 1 exactly when rd_left_o is 0.
- R9: A trigger while rd_left_o>0 is ignored. wr_bank_o and the frozen bank's contents and count are unchanged, and overrun_o becomes 1 and stays 1 until reset.
- R10: A sample and an accepted trigger in the same cycle place that sample as the newest entry of the bank being frozen.
- R11: Samples keep being written into the new write bank while the host reads the frozen bank, with no effect on the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Sample word |
| trig_i | input | 1 | Swap request pulse |
| rd_req_i | input | 1 | Host read strobe |
| rd_data_o | output | DATA_W | Read sample, meaningful while rd_valid_o=1 |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted request |
| rd_done_o | output | 1 | Frozen bank fully read (or empty) |
| rd_left_o | output | $clog2(DEPTH+1) | Samples still unread in the frozen bank |
| wr_bank_o | output | 1 | Index of the bank being written |
| overrun_o | output | 1 | Sticky: a trigger was dropped |

## Verification
Every result here comes from one register stage after the edge that samples the stimulus. wr_bank_o, rd_left_o, rd_done_o and overrun_o reflect a trigger one cycle after it. rd_valid_o and rd_data_o answer a request one cycle after it. The bench drives inputs on the falling edge and holds them through one rising edge. It compares outputs at the next falling edge, so each check lands in the first cycle the result is due. Expected read data is computed from a running sample sequence number and the window length, min(n, DEPTH).

// File: rtl/pp_capture_pkg.sv
package pp_capture_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          swap_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] snap_start_o,
  output logic [CW-1:0] snap_count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_nx;
  logic [CW-1:0] fill_q, fill_nx;

  // state after this cycle's sample, so a same-cycle sample joins the frozen window
  always_comb begin
    wptr_nx = wptr_q;
    fill_nx = fill_q;
    if (push_i) begin
      wptr_nx = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (fill_q != FULL) fill_nx = fill_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (swap_i) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_nx;
      fill_q <= fill_nx;
    end
  end

  assign waddr_o      = wptr_q;
  assign snap_count_o = fill_nx;
  assign snap_start_o = (fill_nx == FULL) ? wptr_nx : '0;

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL);
  p_ptr_moves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !swap_i) |=> (wptr_q != $past(wptr_q)));
  p_same_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && swap_i) |-> (snap_count_o != '0));
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_start_i,
  input  logic [CW-1:0] load_count_i,
  input  logic          req_i,
  output logic          rd_en_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] left_o,
  output logic          valid_o,
  output logic          idle_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] rptr_q;
  logic [CW-1:0] left_q;
  logic          valid_q;

  assign idle_o  = (left_q == '0);
  assign rd_en_o = req_i && !idle_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_o;
      if (load_i) begin
        rptr_q <= load_start_i;
        left_q <= load_count_i;
      end else if (rd_en_o) begin
        rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
        left_q <= left_q - CW'(1);
      end
    end
  end

  assign raddr_o = rptr_q;
  assign left_o  = left_q;
  assign valid_o = valid_q;

  p_left_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CW'(DEPTH));
  p_valid_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && left_q != '0) |=> valid_o && (left_q == $past(left_q) - CW'(1)));
  p_idle_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && left_q == '0 && !load_i) |=> !valid_o && (left_q == '0));
  p_no_load_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (left_q == '0));
endmodule

// File: rtl/pp_capture_buf.sv
module pp_capture_buf
  import pp_capture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NBANK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              trig_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_done_o,
  output logic [CW-1:0]     rd_left_o,
  output logic              wr_bank_o,
  output logic              overrun_o
);
  bank_e         wsel_q;
  logic          rsel_q;
  logic          overrun_q;
  logic          swap;
  logic          rd_idle, rd_en;
  logic [AW-1:0] waddr, raddr, snap_start;
  logic [CW-1:0] snap_count;
  logic [NBANK-1:0]  bank_we, bank_re;
  logic [DATA_W-1:0] bank_rdata [NBANK];

  assign swap = trig_i && rd_idle;

  pp_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (smp_valid_i),
    .swap_i       (swap),
    .waddr_o      (waddr),
    .snap_start_o (snap_start),
    .snap_count_o (snap_count)
  );

  pp_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (swap),
    .load_start_i (snap_start),
    .load_count_i (snap_count),
    .req_i        (rd_req_i),
    .rd_en_o      (rd_en),
    .raddr_o      (raddr),
    .left_o       (rd_left_o),
    .valid_o      (rd_valid_o),
    .idle_o       (rd_idle)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = smp_valid_i && (wsel_q == bank_e'(b));
    assign bank_re[b] = rd_en && (wsel_q != bank_e'(b));
    pp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we[b]),
      .waddr_i (waddr),
      .wdata_i (smp_data_i),
      .re_i    (bank_re[b]),
      .raddr_i (raddr),
      .rdata_o (bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q    <= BANK_A;
      rsel_q    <= 1'b1;
      overrun_q <= 1'b0;
    end else begin
      if (swap) wsel_q <= (wsel_q == BANK_A) ? BANK_B : BANK_A;
      if (trig_i && !rd_idle) overrun_q <= 1'b1;
      if (rd_en) rsel_q <= (wsel_q == BANK_A);
    end
  end

  assign rd_data_o = bank_rdata[rsel_q];
  assign rd_done_o = rd_idle;
  assign wr_bank_o = (wsel_q == BANK_B);
  assign overrun_o = overrun_q;

  p_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && rd_done_o) |=> (wr_bank_o != $past(wr_bank_o)));
  p_ignore_trig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !rd_done_o) |=> $stable(wr_bank_o) && overrun_o);
  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  p_bank_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bank_we[0] && bank_re[0], bank_we[1] && bank_re[1]}) &&
    !(bank_we[0] && bank_re[0]) && !(bank_we[1] && bank_re[1]));
endmodule

// File: tb/pp_capture_buf_tb_top.sv
`timescale 1ns/1ps
module pp_capture_buf_tb_top;
  localparam int DW = 16;
  localparam int D  = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          trig = 1'b0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_done, wr_bank, overrun;
  logic [CW-1:0] rd_left;

  int n_chk = 0, n_err = 0;
  int seq = 1, w_first = 0, w_n = 0;
  int f_first = 0, f_left = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pp_capture_buf #(.DATA_W(DW), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .trig_i(trig), .rd_req_i(rd_req), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rd_done_o(rd_done), .rd_left_o(rd_left), .wr_bank_o(wr_bank), .overrun_o(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: inputs applied at a falling edge, outputs seen at the next one
  task automatic step(input bit v, input bit t, input bit r);
    smp_valid = v; trig = t; rd_req = r; smp_data = DW'(seq);
    @(negedge clk);
    smp_valid = 0; trig = 0; rd_req = 0;
    if (v) begin
      if (w_n == 0) w_first = seq;
      w_n++;
      seq++;
    end
  endtask

  task automatic do_trigger(input bit with_sample);
    int cnt;
    bit old_bank;
    old_bank = wr_bank;
    step(with_sample, 1, 0);
    cnt = (w_n < D) ? w_n : D;
    chk(wr_bank != old_bank, "R3 bank toggle", wr_bank, !old_bank);
    chk(rd_left == CW'(cnt), with_sample ? "R10 count" : "R4 count", rd_left, cnt);
    chk(rd_done == (cnt == 0), "R8 done after swap", rd_done, cnt == 0);
    f_first = w_first + w_n - cnt;
    f_left = cnt;
    w_n = 0;
  endtask

  task automatic drain(input bit interleave);
    int total;
    total = f_left;
    for (int k = 0; k < total; k++) begin
      step(interleave && (k % 2 == 0), 0, 1);
      chk(rd_valid == 1'b1, "R6 valid", rd_valid, 1);
      chk(rd_data == DW'(f_first + k), interleave ? "R11 data" : "R5 data",
          rd_data, f_first + k);
      chk(rd_left == CW'(total - k - 1), "R6 left", rd_left, total - k - 1);
      chk(rd_done == (k == total - 1), "R8 done", rd_done, k == total - 1);
    end
    f_left = 0;
    step(0, 0, 1);
    chk(rd_valid == 1'b0, "R7 idle req", rd_valid, 0);
    chk(rd_left == '0, "R7 left", rd_left, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(rd_valid == 0 && rd_left == 0, "R1 rd idle", rd_left, 0);
    chk(rd_done == 1, "R1 done", rd_done, 1);
    chk(wr_bank == 0, "R1 bank", wr_bank, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep window length across empty, partial, full and wrapped (R2)
    for (int n = 0; n <= 2 * D + 3; n++) begin
      bit same;
      same = (n % 2 == 1);
      for (int i = 0; i < n - (same ? 1 : 0); i++) step(1, 0, 0);
      do_trigger(same);
      drain(n % 4 == 1);
      chk(overrun == 0, "R9 no overrun", overrun, 0);
    end

    // drop a trigger while the frozen bank is unread
    while (w_n > 0) begin
      do_trigger(0);
      drain(0);
    end
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    do_trigger(0);
    begin
      bit b0;
      b0 = wr_bank;
      step(1, 1, 0);
      chk(wr_bank == b0, "R9 bank held", wr_bank, b0);
      chk(overrun == 1, "R9 overrun set", overrun, 1);
      chk(rd_left == CW'(5), "R9 count held", rd_left, 5);
    end
    drain(0);
    chk(overrun == 1, "R9 overrun sticky", overrun, 1);
    do_trigger(0);
    drain(0);
    chk(overrun == 1, "R9 overrun sticky end", overrun, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule